// File: doc/BRIEF.md
# Serial ADC Bring-Up and Conversion Reader

This block is an SPI master that brings a serial delta-sigma converter out of reset and then reads it without pause. As soon as reset is released it sends a 32-bit frame of all ones, which puts the converter's serial interface back into a known state. It then writes four configuration bytes, each in its own chip-select frame.

After that it repeats one cycle for as long as it runs. It sends a read-request byte and waits for the converter's active-low ready line. It then clocks in a 16-bit conversion and presents the result for one system-clock cycle on a sample bus with a strobe.

The serial clock idles high. The master changes MOSI on falling edges and samples MISO on rising edges. The serial clock runs at the system clock divided by an even parameter, and chip select rests high between frames for a guaranteed minimum time.

Top module: `adc_readout_seq`

## Requirements
- R1: While `spi_cs_n` is high, `spi_sclk` is high. After reset both are high and `sample_valid` is low.
- R2: While `spi_cs_n` is low, `spi_mosi` changes only when `spi_sclk` falls. It is stable for the whole time `spi_sclk` is high.
- R3: The first frame after reset is 32 clocks with `spi_mosi` high on every rising edge.
- R4: The next four frames are 8 clocks each and carry, MSB first, 0x20, then 0x0C, then 0x10, then 0x40.
- R5: After the configuration frames, every conversion cycle starts with an 8-clock frame carrying 0x38, MSB first.
- R6: After a 0x38 frame, no further frame starts until `adc_rdy_n` has been low for at least the synchronizer latency (two system clocks by default).
- R7: The read frame is 16 clocks with `spi_mosi` high throughout. The bit on `spi_miso` at the first rising edge becomes bit 15 of the result.
- R8: A received word of 0xFFFF is reported as 0x0000. Every other word is reported unchanged.
- R9: `sample_valid` is high for exactly one system clock per read frame, and `sample_data` is valid in that cycle.
- R10: Between any two frames, and from reset to the first frame, `spi_cs_n` stays high for at least 2*CLK_DIV system clocks.
- R11: Inside a frame, successive rising edges of `spi_sclk` are exactly CLK_DIV system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_miso | input | 1 | Serial data from the converter |
| adc_rdy_n | input | 1 | Converter data-ready, active low, asynchronous |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_cs_n | output | 1 | Chip select, active low |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| sample_data | output | 16 | Conversion result, MSB first as received |

## Verification
The assertions assume that `adc_rdy_n` goes high again before the next read request completes. They also assume that `spi_miso` is stable around each rising `spi_sclk`, which holds when the converter changes it on falling edges. The bench's converter model meets both conditions. It drives MISO only on observed falling edges, holds ready high for a long stretch after each request, and releases it as soon as each read frame ends. The sample words include 0xFFFF, 0x0000 and patterns with only the top or bottom bit set, so the invalid-value rule and the bit order are both exercised.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
   typedef enum logic [2:0] {
      E_IDLE, E_LEAD, E_LOW, E_HIGH, E_GAP
   } eng_state_t;

   typedef enum logic [2:0] {
      Q_WAKE, Q_CFG, Q_REQ, Q_WAIT, Q_READ
   } seq_state_t;

   localparam int          CFG_COUNT   = 4;
   localparam logic [7:0]  REQ_BYTE    = 8'h38;
   localparam logic [31:0] WAKE_WORD   = 32'hFFFF_FFFF;
   localparam int          WAKE_BITS   = 32;
   localparam int          BYTE_BITS   = 8;
   localparam int          SAMPLE_BITS = 16;

   function automatic logic [7:0] cfg_byte(input logic [1:0] idx);
      case (idx)
         2'd0:    cfg_byte = 8'h20;
         2'd1:    cfg_byte = 8'h0C;
         2'd2:    cfg_byte = 8'h10;
         default: cfg_byte = 8'h40;
      endcase
   endfunction
endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("adcseq_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RESET_VAL;
            else        chain <= d_in;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= {chain[STAGES-2:0], d_in};
         end
      end
   endgenerate

   assign d_out = chain[STAGES-1];
endmodule

// File: rtl/adcseq_spi_engine.sv
module adcseq_spi_engine
   import adcseq_pkg::*;
#(
   parameter int CLK_DIV = 16,
   parameter int MAX_BITS = 32,
   parameter int RX_BITS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [5:0]          nbits,
   input  logic [MAX_BITS-1:0] tx_word,
   input  logic                miso,
   output logic                ready,
   output logic                done,
   output logic [RX_BITS-1:0]  rx_word,
   output logic                sclk,
   output logic                mosi,
   output logic                cs_n
);
   localparam int HALF  = CLK_DIV / 2;
   localparam int GAP   = 2 * CLK_DIV;
   localparam int CW    = $clog2(GAP + 1);

   eng_state_t          st;
   logic [CW-1:0]       cnt;
   logic [MAX_BITS-1:0] sh;
   logic [5:0]          bits_left;
   logic [5:0]          sh_amt;
   logic                half_end;
   logic                gap_end;

   assign sh_amt   = 6'(MAX_BITS) - nbits;
   assign half_end = (cnt == CW'(HALF - 1));
   assign gap_end  = (cnt == CW'(GAP - 1));
   assign ready    = (st == E_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= E_GAP;
         cnt       <= '0;
         sh        <= '0;
         bits_left <= '0;
         rx_word   <= '0;
         sclk      <= 1'b1;
         mosi      <= 1'b1;
         cs_n      <= 1'b1;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            E_IDLE: begin
               if (start) begin
                  sh        <= tx_word << sh_amt;
                  bits_left <= nbits;
                  cs_n      <= 1'b0;
                  cnt       <= '0;
                  st        <= E_LEAD;
               end
            end
            E_LEAD: begin
               if (half_end) begin
                  cnt  <= '0;
                  sclk <= 1'b0;
                  mosi <= sh[MAX_BITS-1];
                  sh   <= sh << 1;
                  st   <= E_LOW;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            E_LOW: begin
               if (half_end) begin
                  cnt       <= '0;
                  sclk      <= 1'b1;
                  rx_word   <= {rx_word[RX_BITS-2:0], miso};
                  bits_left <= bits_left - 1'b1;
                  st        <= E_HIGH;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            E_HIGH: begin
               if (half_end) begin
                  cnt <= '0;
                  if (bits_left == '0) begin
                     cs_n <= 1'b1;
                     mosi <= 1'b1;
                     done <= 1'b1;
                     st   <= E_GAP;
                  end else begin
                     sclk <= 1'b0;
                     mosi <= sh[MAX_BITS-1];
                     sh   <= sh << 1;
                     st   <= E_LOW;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            E_GAP: begin
               if (gap_end) begin
                  cnt <= '0;
                  st  <= E_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= E_GAP;
         endcase
      end
   end
endmodule

// File: rtl/adcseq_sample_fmt.sv
module adcseq_sample_fmt #(
   parameter int W         = 16,
   parameter bit ONES_ZERO = 1'b1
) (
   input  logic [W-1:0] raw,
   output logic [W-1:0] cooked
);
   generate
      if (ONES_ZERO) begin : g_filter
         always_comb cooked = (&raw) ? '0 : raw;
      end else begin : g_pass
         always_comb cooked = raw;
      end
   endgenerate
endmodule

// File: rtl/adc_readout_seq.sv
module adc_readout_seq
   import adcseq_pkg::*;
#(
   parameter int CLK_DIV     = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit ONES_ZERO   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        spi_miso,
   input  logic        adc_rdy_n,
   output logic        spi_sclk,
   output logic        spi_mosi,
   output logic        spi_cs_n,
   output logic        sample_valid,
   output logic [15:0] sample_data
);
   localparam int TXW = WAKE_BITS;
   localparam int IDXW = $clog2(CFG_COUNT);

   generate
      if (CLK_DIV < 4 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("adc_readout_seq: CLK_DIV must be even and at least 4");
      end
      if (SAMPLE_BITS > TXW) begin : g_bad_width
         $error("adc_readout_seq: sample wider than shift register");
      end
   endgenerate

   seq_state_t             st;
   logic [IDXW-1:0]        idx;
   logic                   pend;
   logic                   issue;
   logic                   eng_ready;
   logic                   eng_done;
   logic [SAMPLE_BITS-1:0] rx_raw;
   logic [SAMPLE_BITS-1:0] rx_cooked;
   logic                   rdy_s;
   logic [5:0]             nbits;
   logic [TXW-1:0]         tx_word;
   logic                   wants_frame;

   adcseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rdy_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (adc_rdy_n),
      .d_out (rdy_s)
   );

   adcseq_spi_engine #(.CLK_DIV(CLK_DIV), .MAX_BITS(TXW), .RX_BITS(SAMPLE_BITS)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (issue),
      .nbits   (nbits),
      .tx_word (tx_word),
      .miso    (spi_miso),
      .ready   (eng_ready),
      .done    (eng_done),
      .rx_word (rx_raw),
      .sclk    (spi_sclk),
      .mosi    (spi_mosi),
      .cs_n    (spi_cs_n)
   );

   adcseq_sample_fmt #(.W(SAMPLE_BITS), .ONES_ZERO(ONES_ZERO)) u_fmt (
      .raw    (rx_raw),
      .cooked (rx_cooked)
   );

   always_comb begin
      wants_frame = 1'b1;
      nbits       = 6'(BYTE_BITS);
      tx_word     = '0;
      case (st)
         Q_WAKE: begin
            nbits   = 6'(WAKE_BITS);
            tx_word = WAKE_WORD;
         end
         Q_CFG:  tx_word = {{(TXW-8){1'b0}}, cfg_byte(2'(idx))};
         Q_REQ:  tx_word = {{(TXW-8){1'b0}}, REQ_BYTE};
         Q_READ: begin
            nbits   = 6'(SAMPLE_BITS);
            tx_word = {{(TXW-SAMPLE_BITS){1'b0}}, {SAMPLE_BITS{1'b1}}};
         end
         default: wants_frame = 1'b0;
      endcase
   end

   assign issue = wants_frame && !pend && eng_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= Q_WAKE;
         idx          <= '0;
         pend         <= 1'b0;
         sample_valid <= 1'b0;
         sample_data  <= '0;
      end else begin
         sample_valid <= 1'b0;
         if (issue) pend <= 1'b1;
         case (st)
            Q_WAKE: if (pend && eng_done) begin
               pend <= 1'b0;
               idx  <= '0;
               st   <= Q_CFG;
            end
            Q_CFG: if (pend && eng_done) begin
               pend <= 1'b0;
               if (idx == IDXW'(CFG_COUNT - 1)) st <= Q_REQ;
               else idx <= idx + 1'b1;
            end
            Q_REQ: if (pend && eng_done) begin
               pend <= 1'b0;
               st   <= Q_WAIT;
            end
            Q_WAIT: if (!rdy_s) st <= Q_READ;
            Q_READ: if (pend && eng_done) begin
               pend         <= 1'b0;
               sample_valid <= 1'b1;
               sample_data  <= rx_cooked;
               st           <= Q_REQ;
            end
            default: st <= Q_WAKE;
         endcase
      end
   end
endmodule

// File: rtl/adc_readout_seq_chk.sv
module adc_readout_seq_chk #(
   parameter int CLK_DIV = 16
) (
   input logic        clk,
   input logic        rst_n,
   input logic        spi_sclk,
   input logic        spi_mosi,
   input logic        spi_cs_n,
   input logic        sample_valid,
   input logic [15:0] sample_data
);
   localparam int GAPW = $clog2(2 * CLK_DIV + 2);
   logic [GAPW-1:0] gap_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gap_cnt <= '0;
      else if (!spi_cs_n) gap_cnt <= '0;
      else if (gap_cnt != GAPW'(2 * CLK_DIV + 1)) gap_cnt <= gap_cnt + 1'b1;
   end

   assert_idle_clock_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> spi_sclk);

   assert_clock_moves_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_sclk) |-> !spi_cs_n);

   assert_mosi_held_while_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n && !$past(spi_cs_n) && spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

   assert_no_all_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |-> (sample_data != 16'hFFFF));

   assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |=> !sample_valid);

   assert_cs_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> (gap_cnt >= GAPW'(2 * CLK_DIV)));
endmodule

bind adc_readout_seq adc_readout_seq_chk #(.CLK_DIV(CLK_DIV)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .spi_sclk     (spi_sclk),
   .spi_mosi     (spi_mosi),
   .spi_cs_n     (spi_cs_n),
   .sample_valid (sample_valid),
   .sample_data  (sample_data)
);

// File: tb/adc_readout_seq_test.sv
module adc_readout_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 16;
   localparam int NWORDS     = 6;
   localparam int RDY_DELAY  = 150;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_miso = 1'b1;
   logic        adc_rdy_n = 1'b1;
   logic        spi_sclk, spi_mosi, spi_cs_n, sample_valid;
   logic [15:0] sample_data;

   int vectors = 0;
   int miscompares = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_readout_seq #(.CLK_DIV(DIV)) uut (
      .clk(clk), .rst_n(rst_n), .spi_miso(spi_miso), .adc_rdy_n(adc_rdy_n),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
      .sample_valid(sample_valid), .sample_data(sample_data)
   );

   // behavioural converter model and expectations
   logic [15:0] words [NWORDS] = '{16'h1234, 16'hFFFF, 16'h0000, 16'h8001, 16'hA5A5, 16'h7FFE};
   int          exp_len [$];
   logic [31:0] exp_val [$];
   logic [15:0] exp_samp [$];

   logic        prev_sclk = 1'b1, prev_cs = 1'b1, prev_mosi = 1'b1, prev_valid = 1'b0;
   logic [31:0] fval = '0;
   int          flen = 0, fcount = 0, since_rise = 0, cs_high = 0;
   int          conv = 0, got = 0, rdy_timer = -1, cycles = 0;
   bit          waiting = 0, running = 0;
   logic [15:0] slave_sh = '0;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic bit is_read(input int fc);
      return (fc >= 5) && (((fc - 5) % 2) == 1);
   endfunction

   always @(negedge clk) begin
      if (running) begin
         cycles++;
         since_rise++;
         // R1: clock idles high outside frames (every cycle)
         check(!(spi_cs_n && !spi_sclk), "R1", spi_sclk, 1);
         // R2: MOSI constant while SCLK high inside a frame
         if (!spi_cs_n && !prev_cs && spi_sclk && prev_sclk)
            check(spi_mosi == prev_mosi, "R2", spi_mosi, prev_mosi);
         // frame start
         if (prev_cs && !spi_cs_n) begin
            check(cs_high >= 2*DIV, "R10", cs_high, 2*DIV);
            if (is_read(fcount)) begin
               check(!waiting, "R6", waiting, 0);
               slave_sh = words[conv];
            end
            flen = 0; fval = '0;
         end
         if (spi_cs_n) cs_high++; else cs_high = 0;
         // rising SCLK: capture MOSI, check period
         if (!spi_cs_n && !prev_sclk && spi_sclk) begin
            if (flen > 0) check(since_rise == DIV, "R11", since_rise, DIV);
            fval = {fval[30:0], spi_mosi};
            flen++;
            since_rise = 0;
         end
         // falling SCLK: converter shifts next bit out
         if (!spi_cs_n && prev_sclk && !spi_sclk && is_read(fcount)) begin
            spi_miso <= slave_sh[15];
            slave_sh = slave_sh << 1;
         end
         // frame end
         if (!prev_cs && spi_cs_n) begin
            if (exp_len.size() == 0) begin
               check(0, "R5", flen, 0);
            end else begin
               automatic int          el = exp_len.pop_front();
               automatic logic [31:0] ev = exp_val.pop_front();
               automatic string       rq = (fcount == 0) ? "R3" : (fcount < 5) ? "R4" :
                                           is_read(fcount) ? "R7" : "R5";
               check(flen == el, rq, flen, el);
               check(fval == ev, rq, fval, ev);
            end
            if (fcount >= 5 && !is_read(fcount)) begin
               rdy_timer = RDY_DELAY;
               waiting = 1;
            end
            if (is_read(fcount)) begin
               adc_rdy_n <= 1'b1;
               spi_miso <= 1'b1;
               exp_samp.push_back((words[conv] == 16'hFFFF) ? 16'h0000 : words[conv]);
               conv++;
            end
            fcount++;
         end
         // ready line pacing
         if (rdy_timer > 0) rdy_timer--;
         else if (rdy_timer == 0) begin
            if (conv < NWORDS) begin
               adc_rdy_n <= 1'b0;
               waiting = 0;
            end
            rdy_timer = -1;
         end
         // sample strobe checks
         if (sample_valid) begin
            check(!prev_valid, "R9", prev_valid, 0);
            if (exp_samp.size() == 0) check(0, "R9", sample_data, 0);
            else begin
               automatic logic [15:0] es = exp_samp.pop_front();
               check(sample_data == es, (es == 16'h0 && got == 1) ? "R8" : "R7", sample_data, es);
            end
            got++;
         end
         prev_sclk  = spi_sclk;
         prev_cs    = spi_cs_n;
         prev_mosi  = spi_mosi;
         prev_valid = sample_valid;
      end
   end

   initial begin
      exp_len.push_back(32); exp_val.push_back(32'hFFFF_FFFF);
      exp_len.push_back(8);  exp_val.push_back(32'h20);
      exp_len.push_back(8);  exp_val.push_back(32'h0C);
      exp_len.push_back(8);  exp_val.push_back(32'h10);
      exp_len.push_back(8);  exp_val.push_back(32'h40);
      for (int i = 0; i < NWORDS; i++) begin
         exp_len.push_back(8);  exp_val.push_back(32'h38);
         exp_len.push_back(16); exp_val.push_back(32'hFFFF);
      end
      exp_len.push_back(8); exp_val.push_back(32'h38);

      repeat (4) @(negedge clk);
      // R1: reset state
      check(spi_cs_n == 1'b1, "R1", spi_cs_n, 1);
      check(spi_sclk == 1'b1, "R1", spi_sclk, 1);
      check(sample_valid == 1'b0, "R9", sample_valid, 0);
      rst_n = 1'b1;
      running = 1;
      while (got < NWORDS && cycles < WATCHDOG) @(negedge clk);
      if (cycles >= WATCHDOG) check(0, "watchdog", cycles, WATCHDOG);
      repeat (3 * DIV) @(negedge clk);
      check(got == NWORDS, "R9", got, NWORDS);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule